// File: doc/BRIEF.md
# Endian-Configurable Load Data Aligner

This block sits on the load return path of a processor, between a 32-bit memory read port and the register file write port. Each request carries the full memory word, the access size (byte, halfword or word), a signed/unsigned flag and the low two address bits. It also carries the byte-order mode, which is sampled with the request. The block picks the addressed bytes from the word and arranges them for the selected byte order. It then sign-extends or zero-extends the quantity to 32 bits.

The result is registered. It appears one cycle after the request is accepted, behind a valid/ready handshake. If the output is stalled, the result is held and no new request is taken. A flag reports halfword or word accesses that are not naturally aligned. The data returned with that flag set has no defined value.

Top module: `load_aligner`

## Requirements
- R1: While reset is asserted, and until the internal reset release has passed its two synchronizing stages, `rsp_valid` and `req_ready` are both 0.
- R2: A byte access (size code 2'b00) returns the byte on bus lanes `8*k+7:8*k`, where k is the offset. The memory byte at offset k always travels on those lanes. The low 8 bits of the result are the same in both byte-order modes.
- R3: A halfword access (size code 2'b01) in little-endian mode (`mode_big`=0) returns the lower-addressed byte in bits 7:0 and the higher-addressed byte in bits 15:8.
- R4: A halfword access in big-endian mode (`mode_big`=1) returns the lower-addressed byte in bits 15:8 and the higher-addressed byte in bits 7:0.
- R5: A word access (size code 2'b10, with 2'b11 handled the same way) returns the bus word unchanged in little-endian mode. In big-endian mode it returns the bus word with its four bytes reversed.
- R6: A signed (`req_signed`=1) byte or halfword result copies the top bit of the selected quantity into all upper result bits.
- R7: An unsigned byte or halfword result has all bits above the selected quantity at 0.
- R8: `rsp_misaligned` is 1 for a halfword access with offset bit 0 set, or for a word access with a non-zero offset. It is 0 for every other access.
- R9: The byte-order mode takes effect per request. Alternating the mode between back-to-back requests gives each result the order that was present when that request was accepted.
- R10: A request is accepted when `req_valid` and `req_ready` are both 1. Its result appears on `rsp_valid` in the next cycle. `req_ready` is 1 exactly when no result is held or the held result is being taken.
- R11: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_data` and `rsp_misaligned` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_big | input | 1 | Byte-order mode: 1 big-endian, 0 little-endian |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_word | input | 32 | Memory word; offset k on lanes 8k+7:8k |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_signed | input | 1 | 1 sign-extend, 0 zero-extend |
| req_ofs | input | 2 | Low address bits of the access |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | 32 | Aligned, extended load value |
| rsp_misaligned | output | 1 | Access was not naturally aligned |

## Verification
The bench builds the block with its default parameters: 8-bit lanes, four lanes and two reset-release stages. With these values the offset has four settings, so the bench can reach every byte lane, both halfword positions and all three misaligned offsets of a word. It also covers both byte orders on each of them. The two-stage reset release sets the cycle in which `req_ready` can first rise. Back-pressure from a pseudo-random `rsp_ready` pattern exercises the stall hold while the mode input toggles.

// File: rtl/load_align_pkg.sv
package load_align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/load_rst_sync.sv
module load_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_q = chain_q[STAGES-1];
endmodule

// File: rtl/load_lane_select.sv
module load_lane_select
  import load_align_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  localparam int DATA_W = LANE_W * LANES,
  localparam int OFS_W  = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] word,
  input  acc_size_e         size,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              big,
  output logic [DATA_W-1:0] sel
);
  logic [LANE_W-1:0] lane [LANES];
  logic [LANE_W-1:0] byte_q;
  logic [OFS_W-1:0]  half_base;
  logic [2*LANE_W-1:0] half_q;
  logic [DATA_W-1:0] word_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word[g*LANE_W +: LANE_W];
  end

  assign byte_q    = lane[ofs];
  assign half_base = {ofs[OFS_W-1:1], 1'b0};

  // Result byte h of a halfword: lower address goes low in little-endian, high in big-endian
  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam logic [OFS_W-1:0] LE_IDX = OFS_W'(h);
    localparam logic [OFS_W-1:0] BE_IDX = OFS_W'(1 - h);
    logic [OFS_W-1:0] idx;
    assign idx = big ? (half_base | BE_IDX) : (half_base | LE_IDX);
    assign half_q[h*LANE_W +: LANE_W] = lane[idx];
  end

  for (genvar w = 0; w < LANES; w++) begin : g_word
    assign word_q[w*LANE_W +: LANE_W] = big ? lane[LANES-1-w] : lane[w];
  end

  always_comb begin
    sel = '0;
    unique case (size)
      SZ_BYTE: sel[LANE_W-1:0]   = byte_q;
      SZ_HALF: sel[2*LANE_W-1:0] = half_q;
      default: sel               = word_q;
    endcase
  end
endmodule

// File: rtl/load_extend.sv
module load_extend
  import load_align_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic [DATA_W-1:0] sel,
  input  acc_size_e         size,
  input  logic              is_signed,
  output logic [DATA_W-1:0] ext
);
  logic fill_b;
  logic fill_h;

  assign fill_b = is_signed & sel[LANE_W-1];
  assign fill_h = is_signed & sel[2*LANE_W-1];

  always_comb begin
    unique case (size)
      SZ_BYTE: ext = {{(DATA_W-LANE_W){fill_b}}, sel[LANE_W-1:0]};
      SZ_HALF: ext = {{(DATA_W-2*LANE_W){fill_h}}, sel[2*LANE_W-1:0]};
      default: ext = sel;
    endcase
  end
endmodule

// File: rtl/load_align_check.sv
module load_align_check
  import load_align_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  acc_size_e        size,
  input  logic [OFS_W-1:0] ofs,
  output logic             misaligned
);
  always_comb begin
    unique case (size)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = ofs[0];
      default: misaligned = |ofs;
    endcase
  end
endmodule

// File: rtl/load_out_reg.sv
module load_out_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] d_data,
  input  logic              d_mis,
  input  logic              rsp_ready,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_data,
  output logic              q_mis
);
  logic valid_d;

  always_comb begin
    if (load_en)        valid_d = 1'b1;
    else if (rsp_ready) valid_d = 1'b0;
    else                valid_d = q_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_valid <= 1'b0;
    else        q_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_data <= '0;
      q_mis  <= 1'b0;
    end else if (load_en) begin
      q_data <= d_data;
      q_mis  <= d_mis;
    end
  end

  assert_accept_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> q_valid);

  assert_hold_while_stalled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !rsp_ready) |=> (q_valid && $stable(q_data) && $stable(q_mis)));
endmodule

// File: rtl/load_aligner.sv
module load_aligner
  import load_align_pkg::*;
#(
  parameter int LANE_W      = 8,
  parameter int LANES       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int DATA_W = LANE_W * LANES,
  localparam int OFS_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              mode_big,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DATA_W-1:0] req_word,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [OFS_W-1:0]  req_ofs,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_misaligned
);
  logic              rst_q;
  logic              accept;
  acc_size_e         size_e;
  logic [DATA_W-1:0] sel_w;
  logic [DATA_W-1:0] ext_w;
  logic              mis_w;

  assign size_e = acc_size_e'(req_size);

  load_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_q(rst_q)
  );

  load_lane_select #(.LANE_W(LANE_W), .LANES(LANES)) u_sel (
    .word(req_word), .size(size_e), .ofs(req_ofs), .big(mode_big), .sel(sel_w)
  );

  load_extend #(.LANE_W(LANE_W), .LANES(LANES)) u_ext (
    .sel(sel_w), .size(size_e), .is_signed(req_signed), .ext(ext_w)
  );

  load_align_check #(.OFS_W(OFS_W)) u_chk (
    .size(size_e), .ofs(req_ofs), .misaligned(mis_w)
  );

  assign req_ready = rst_q & (~rsp_valid | rsp_ready);
  assign accept    = req_valid & req_ready;

  load_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_q), .load_en(accept),
    .d_data(ext_w), .d_mis(mis_w), .rsp_ready(rsp_ready),
    .q_valid(rsp_valid), .q_data(rsp_data), .q_mis(rsp_misaligned)
  );

  // Reference view of the addressed lane, for the checks below
  logic [DATA_W-1:0] req_shifted;
  assign req_shifted = req_word >> (LANE_W * int'(req_ofs));

  assert_byte_lane_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (accept && size_e == SZ_BYTE) |=> rsp_data[LANE_W-1:0] == $past(req_shifted[LANE_W-1:0]));

  assert_sign_fill_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (accept && size_e == SZ_BYTE && req_signed)
      |=> rsp_data[DATA_W-1:LANE_W] == {(DATA_W-LANE_W){rsp_data[LANE_W-1]}});

  assert_zero_fill_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (accept && size_e == SZ_BYTE && !req_signed) |=> rsp_data[DATA_W-1:LANE_W] == '0);

  assert_misalign_flag_R8: assert property (@(posedge clk) disable iff (!rst_q)
    accept |=> rsp_misaligned ==
      (($past(size_e) == SZ_HALF && $past(req_ofs[0])) ||
       ($past(size_e) != SZ_BYTE && $past(size_e) != SZ_HALF && $past(req_ofs) != '0)));
endmodule

// File: tb/load_aligner_bench.sv
module load_aligner_bench;
  logic        clk = 1'b0;
  logic        arst_n;
  logic        mode_big;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_word;
  logic [1:0]  req_size;
  logic        req_signed;
  logic [1:0]  req_ofs;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [31:0] rsp_data;
  logic        rsp_misaligned;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  logic        bp_en = 1'b0;
  logic [7:0]  lfsr = 8'hA5;
  logic [32:0] exp_q[$];
  string       tag_q[$];
  logic        hold_pend = 1'b0;
  logic [32:0] hold_val;

  always #5 clk = ~clk;

  load_aligner u_load_aligner (
    .clk(clk), .arst_n(arst_n), .mode_big(mode_big),
    .req_valid(req_valid), .req_ready(req_ready), .req_word(req_word),
    .req_size(req_size), .req_signed(req_signed), .req_ofs(req_ofs),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_misaligned(rsp_misaligned)
  );

  function automatic logic [32:0] model(input logic [31:0] w, input logic [1:0] sz,
                                        input logic sg, input logic [1:0] of, input logic bg);
    logic [7:0]  b [4];
    logic [31:0] v;
    logic        mis;
    for (int k = 0; k < 4; k++) b[k] = w[8*k +: 8];
    mis = 1'b0;
    if (sz == 2'b00) begin
      v = {24'h0, b[of]};
      if (sg && v[7]) v[31:8] = 24'hFFFFFF;
    end else if (sz == 2'b01) begin
      mis = of[0];
      v = bg ? {16'h0, b[{of[1], 1'b0}], b[{of[1], 1'b1}]}
             : {16'h0, b[{of[1], 1'b1}], b[{of[1], 1'b0}]};
      if (sg && v[15]) v[31:16] = 16'hFFFF;
    end else begin
      mis = (of != 2'b00);
      v = bg ? {b[0], b[1], b[2], b[3]} : w;
    end
    return {mis, v};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input string tag, input logic [31:0] w, input logic [1:0] sz,
                      input logic sg, input logic [1:0] of, input logic bg);
    @(negedge clk);
    #2;
    req_word = w; req_size = sz; req_signed = sg; req_ofs = of; mode_big = bg;
    req_valid = 1'b1;
    exp_q.push_back(model(w, sz, sg, of, bg));
    tag_q.push_back(tag);
    while (!req_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    mode_big  = ~bg;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || rsp_valid) @(negedge clk);
  endtask

  // Monitor: pick rsp_ready, then compare whatever is taken at the next edge
  always @(negedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (hold_pend) begin
      check("R11 stalled valid", {31'h0, rsp_valid}, 32'h1);
      check("R11 stalled data", rsp_data, hold_val[31:0]);
      check("R11 stalled flag", {31'h0, rsp_misaligned}, {31'h0, hold_val[32]});
    end
    rsp_ready = bp_en ? lfsr[0] : 1'b1;
    hold_pend = rsp_valid && !rsp_ready;
    hold_val  = {rsp_misaligned, rsp_data};
    if (rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected result", 32'h1, 32'h0);
      end else begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " flag"}, {31'h0, rsp_misaligned}, {31'h0, e[32]});
        if (!e[32]) check(t, rsp_data, e[31:0]);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected<=50000 cycles", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0; mode_big = 1'b0; req_valid = 1'b0; req_word = '0;
    req_size = 2'b00; req_signed = 1'b0; req_ofs = 2'b00; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
    check("R1 reset req_ready", {31'h0, req_ready}, 32'h0);
    arst_n = 1'b1;
    @(negedge clk);
    #2;
    check("R1 sync release req_ready", {31'h0, req_ready}, 32'h0);
    repeat (2) @(negedge clk);
    #2;
    check("R1 after release req_ready", {31'h0, req_ready}, 32'h1);

    // R10: idle send, result exactly one cycle after acceptance
    @(negedge clk);
    #2;
    req_word = 32'hDDCCBBAA; req_size = 2'b00; req_signed = 1'b1; req_ofs = 2'b00;
    mode_big = 1'b0; req_valid = 1'b1;
    exp_q.push_back(model(32'hDDCCBBAA, 2'b00, 1'b1, 2'b00, 1'b0));
    tag_q.push_back("R10 first result");
    check("R10 idle req_ready", {31'h0, req_ready}, 32'h1);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    @(negedge clk);
    check("R10 rsp_valid next cycle", {31'h0, rsp_valid}, 32'h1);
    drain();

    // Memory AA BB CC DD at offsets 0..3
    send("R2 signed byte LE", 32'hDDCCBBAA, 2'b00, 1'b1, 2'd0, 1'b0);
    send("R2 signed byte BE", 32'hDDCCBBAA, 2'b00, 1'b1, 2'd0, 1'b1);
    send("R3 signed half LE", 32'hDDCCBBAA, 2'b01, 1'b1, 2'd0, 1'b0);
    send("R4 signed half BE", 32'hDDCCBBAA, 2'b01, 1'b1, 2'd0, 1'b1);
    send("R5 word LE", 32'hDDCCBBAA, 2'b10, 1'b0, 2'd0, 1'b0);
    send("R5 word BE", 32'hDDCCBBAA, 2'b10, 1'b0, 2'd0, 1'b1);
    send("R5 reserved size as word BE", 32'hDDCCBBAA, 2'b11, 1'b0, 2'd0, 1'b1);
    // Word 0x04050607 stored in each order, byte at the base address read back
    send("R2 stored word LE byte0", 32'h04050607, 2'b00, 1'b0, 2'd0, 1'b0);
    send("R2 stored word BE byte0", 32'h07060504, 2'b00, 1'b0, 2'd0, 1'b1);
    for (int k = 0; k < 4; k++) begin
      send("R2 byte lane LE", 32'h8E3C7F15, 2'b00, 1'b0, 2'(k), 1'b0);
      send("R2 byte lane BE", 32'h8E3C7F15, 2'b00, 1'b1, 2'(k), 1'b1);
      send("R6 signed byte", 32'h8E3C7F95, 2'b00, 1'b1, 2'(k), k[0]);
    end
    send("R7 unsigned byte neg", 32'h000000F0, 2'b00, 1'b0, 2'd0, 1'b0);
    send("R7 unsigned half LE", 32'h9A80FFFF, 2'b01, 1'b0, 2'd2, 1'b0);
    send("R7 unsigned half BE", 32'h9A80FFFF, 2'b01, 1'b0, 2'd2, 1'b1);
    send("R6 signed half hi LE", 32'h9A807F00, 2'b01, 1'b1, 2'd2, 1'b0);
    send("R6 signed half hi BE", 32'h9A807F00, 2'b01, 1'b1, 2'd2, 1'b1);
    send("R6 positive half LE", 32'h00007F12, 2'b01, 1'b1, 2'd0, 1'b0);
    send("R8 half ofs1", 32'h11223344, 2'b01, 1'b0, 2'd1, 1'b0);
    send("R8 half ofs3", 32'h11223344, 2'b01, 1'b1, 2'd3, 1'b1);
    send("R8 half ofs2 aligned", 32'h11223344, 2'b01, 1'b0, 2'd2, 1'b0);
    send("R8 word ofs1", 32'h11223344, 2'b10, 1'b0, 2'd1, 1'b0);
    send("R8 word ofs2", 32'h11223344, 2'b10, 1'b0, 2'd2, 1'b1);
    send("R8 word ofs3", 32'h11223344, 2'b10, 1'b0, 2'd3, 1'b0);
    send("R8 byte ofs3 aligned", 32'h11223344, 2'b00, 1'b0, 2'd3, 1'b0);
    drain();

    // R9 and R11: alternating mode under back-pressure
    bp_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      logic [31:0] w;
      w = 32'h1357_9BDF ^ (32'h0F0F_3355 * i);
      send("R9 alternating mode", w, 2'(i % 3), i[1], 2'((i % 3 == 0) ? i : (i & 2)), i[0]);
    end
    drain();
    bp_en = 1'b0;
    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule